// File: doc/BRIEF.md
# Interrupt flag and enable unit

This block collects seven interrupt sources for a byte-wide peripheral register bus and turns them into one active-low interrupt request. Four of the sources are edges on external control lines (two lines per port side, called A1, A2, B1 and B2 here). The other three are single-cycle event pulses from neighbouring logic: a shift-register completion and two timer underflows. A control register picks the active edge of each control line, and for the two secondary lines it also selects whether the line raises interrupts at all.

Software reads the flag register to see which sources fired. It clears flags by writing ones to them. It chooses which flags may assert the request line through an enable register, which it updates with set-or-clear writes. A build parameter selects a stricter clear rule: a flag write takes effect only when the top bit of the written byte is also one.

Top module: `irq_unit`

## Requirements
- R1: After a synchronous reset the flags, the enables and the edge control register are all zero, and `irq_n` is 1. Each control line's edge history is loaded with the level the line has during reset.
- R2: Register offsets are 0 for edge control, 1 for flags and 2 for enables. A write to offset 2 with bit 7 = 1 sets the enable bits whose data bits are 1. With bit 7 = 0 it clears those bits. Other enable bits keep their value. A read of offset 2 returns the enables in bits 6..0 and a 1 in bit 7.
- R3: A write of 0x7F to the enable register disables every source, and `irq_n` is 1 from the next cycle onward.
- R4: With `CLR_NEEDS_TOP` = 0, a write to the flag register clears every flag whose data bit is 1, whatever the value of bit 7.
- R5: With `CLR_NEEDS_TOP` = 1, a flag write clears flags only when bit 7 of the written byte is 1. A flag write with bit 7 = 0 leaves every flag as it was.
- R6: Flags latch whether or not their source is enabled. A read of offset 1 returns the flags in bits 6..0. Bit 7 of that read is 1 exactly when some flag is set and enabled, and `irq_n` is the inverse of that bit.
- R7: In the edge control register, bit 0 selects the active edge of line A1 and bit 4 selects the active edge of line B1. A value of 0 means a falling edge and 1 means a rising edge. An edge of the other polarity sets no flag.
- R8: Bits 3..1 form the mode of line A2 and bits 7..5 form the mode of line B2. If the mode's top bit is 0, the line is an input and the mode's middle bit picks a rising (1) or falling (0) edge. So 0x22 gives falling edges on all four lines, and 0x66 gives falling edges on A1/B1 and rising edges on A2/B2. If the mode's top bit is 1, the line never sets its flag.
- R9: Flag bit positions are A2 = 0, A1 = 1, shift event = 2, B2 = 3, B1 = 4, timer 2 = 5 and timer 1 = 6. A pulse on an event input sets its flag.
- R10: A source event in the same cycle as a flag write that clears the same bit leaves the flag set.
- R11: A flag is set on the clock edge at which its event is sampled, and both the read value and `irq_n` show it right after that edge. The edge control value in force before a write governs the edge sampled together with that write. Flags that are neither set nor cleared hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when no access |
| line_a1 | input | 1 | Control line A1 |
| line_a2 | input | 1 | Control line A2 |
| line_b1 | input | 1 | Control line B1 |
| line_b2 | input | 1 | Control line B2 |
| evt_t1 | input | 1 | Timer 1 underflow pulse |
| evt_t2 | input | 1 | Timer 2 underflow pulse |
| evt_sr | input | 1 | Shift completion pulse |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds two copies of the unit side by side: one with `CLR_NEEDS_TOP` = 0 and one with `CLR_NEEDS_TOP` = 1. Both copies receive the same bus traffic and the same line activity. A flag write with bit 7 clear therefore shows, in the same cycle, a cleared flag on one copy and a kept flag on the other. Random traffic then mixes writes of the edge mode with line toggles, and covers mode changes that take effect one edge after the write and clears that race against new events on both rules.

// File: rtl/irqu_pkg.sv
package irqu_pkg;

    localparam int DATA_W  = 8;
    localparam int SRC_W   = DATA_W - 1;
    localparam int N_LINES = 4;
    localparam int ADDR_W  = 2;

    // flag bit positions
    localparam int B_A2 = 0;
    localparam int B_A1 = 1;
    localparam int B_SR = 2;
    localparam int B_B2 = 3;
    localparam int B_B1 = 4;
    localparam int B_T2 = 5;
    localparam int B_T1 = 6;

    // control line indices inside the edge detector
    localparam int L_A1 = 0;
    localparam int L_A2 = 1;
    localparam int L_B1 = 2;
    localparam int L_B2 = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_FLAG = 2'd1,
        REG_ENAB = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [2:0] b2_mode;
        logic       b1_rise;
        logic [2:0] a2_mode;
        logic       a1_rise;
    } edge_ctrl_t;

    typedef struct packed {
        logic [N_LINES-1:0] rise;
        logic [N_LINES-1:0] armed;
    } line_cfg_t;

    function automatic logic mode_is_input(input logic [2:0] m);
        return ~m[2];
    endfunction

    function automatic logic mode_rises(input logic [2:0] m);
        return m[1];
    endfunction

    function automatic line_cfg_t decode_cfg(input edge_ctrl_t c);
        line_cfg_t r;
        r.rise[L_A1]  = c.a1_rise;
        r.armed[L_A1] = 1'b1;
        r.rise[L_B1]  = c.b1_rise;
        r.armed[L_B1] = 1'b1;
        r.rise[L_A2]  = mode_rises(c.a2_mode);
        r.armed[L_A2] = mode_is_input(c.a2_mode);
        r.rise[L_B2]  = mode_rises(c.b2_mode);
        r.armed[L_B2] = mode_is_input(c.b2_mode);
        return r;
    endfunction

endpackage

// File: rtl/irqu_edge_detect.sv
module irqu_edge_detect #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines_i,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] armed_i,
    output logic [N-1:0] hit_o
);

    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk) begin
            prev_q[i] <= lines_i[i];
        end

        logic went_up;
        logic went_down;
        assign went_up   = ~prev_q[i] &  lines_i[i];
        assign went_down =  prev_q[i] & ~lines_i[i];
        assign hit_o[i]  = ~rst & armed_i[i] & (rise_i[i] ? went_up : went_down);
    end

endmodule

// File: rtl/irqu_flag_reg.sv
module irqu_flag_reg #(
    parameter int W             = 7,
    parameter bit CLR_NEEDS_TOP = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_wr_i,
    input  logic [W:0]   wdata_i,
    output logic [W-1:0] flags_o
);

    logic         gate;
    logic [W-1:0] clr_mask;
    logic [W-1:0] flags_q;

    if (CLR_NEEDS_TOP) begin : g_guarded
        assign gate = wdata_i[W];
    end else begin : g_plain
        assign gate = 1'b1;
    end

    assign clr_mask = (clr_wr_i && gate) ? wdata_i[W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_mask) | set_i;
        end
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/irqu_enable_reg.sv
module irqu_enable_reg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W:0]   wdata_i,
    output logic [W-1:0] en_o
);

    logic [W-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_i) begin
            if (wdata_i[W]) begin
                en_q <= en_q | wdata_i[W-1:0];
            end else begin
                en_q <= en_q & ~wdata_i[W-1:0];
            end
        end
    end

    assign en_o = en_q;

endmodule

// File: rtl/irq_unit.sv
module irq_unit
    import irqu_pkg::*;
#(
    parameter bit CLR_NEEDS_TOP = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              line_a1,
    input  logic              line_a2,
    input  logic              line_b1,
    input  logic              line_b2,
    input  logic              evt_t1,
    input  logic              evt_t2,
    input  logic              evt_sr,
    output logic              irq_n
);

    logic               wr_stb;
    reg_sel_e           sel;
    edge_ctrl_t         ctrl_q;
    line_cfg_t          cfg;
    logic [N_LINES-1:0] lines;
    logic [N_LINES-1:0] hits;
    logic [SRC_W-1:0]   set_vec;
    logic [SRC_W-1:0]   flag_q;
    logic [SRC_W-1:0]   en_q;
    logic               any_pending;

    assign wr_stb = bus_en & bus_we;
    assign sel    = reg_sel_e'(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_stb && sel == REG_CTRL) begin
            ctrl_q <= edge_ctrl_t'(bus_wdata);
        end
    end

    assign cfg = decode_cfg(ctrl_q);

    always_comb begin
        lines       = '0;
        lines[L_A1] = line_a1;
        lines[L_A2] = line_a2;
        lines[L_B1] = line_b1;
        lines[L_B2] = line_b2;
    end

    irqu_edge_detect #(.N(N_LINES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .lines_i (lines),
        .rise_i  (cfg.rise),
        .armed_i (cfg.armed),
        .hit_o   (hits)
    );

    always_comb begin
        set_vec       = '0;
        set_vec[B_A2] = hits[L_A2];
        set_vec[B_A1] = hits[L_A1];
        set_vec[B_SR] = evt_sr;
        set_vec[B_B2] = hits[L_B2];
        set_vec[B_B1] = hits[L_B1];
        set_vec[B_T2] = evt_t2;
        set_vec[B_T1] = evt_t1;
    end

    irqu_flag_reg #(.W(SRC_W), .CLR_NEEDS_TOP(CLR_NEEDS_TOP)) u_flag (
        .clk      (clk),
        .rst      (rst),
        .set_i    (set_vec),
        .clr_wr_i (wr_stb && sel == REG_FLAG),
        .wdata_i  (bus_wdata),
        .flags_o  (flag_q)
    );

    irqu_enable_reg #(.W(SRC_W)) u_enab (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr_stb && sel == REG_ENAB),
        .wdata_i (bus_wdata),
        .en_o    (en_q)
    );

    assign any_pending = |(flag_q & en_q);
    assign irq_n       = ~any_pending;

    always_comb begin
        bus_rdata = '0;
        if (bus_en) begin
            unique case (sel)
                REG_CTRL: bus_rdata = ctrl_q;
                REG_FLAG: bus_rdata = {any_pending, flag_q};
                REG_ENAB: bus_rdata = {1'b1, en_q};
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irqu_checker.sv
module irqu_checker
    import irqu_pkg::*;
#(
    parameter bit CLR_NEEDS_TOP = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_n,
    input logic [SRC_W-1:0]  flags,
    input logic [SRC_W-1:0]  enables,
    input logic [SRC_W-1:0]  set_vec
);

    logic wr_flag;
    logic wr_enab;
    assign wr_flag = bus_en && bus_we && bus_addr == REG_FLAG;
    assign wr_enab = bus_en && bus_we && bus_addr == REG_ENAB;

    p_enable_set_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_enab && bus_wdata[7]) |=>
        ((enables & $past(bus_wdata[6:0])) == $past(bus_wdata[6:0])));

    p_enable_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_enab && !bus_wdata[7]) |=> ((enables & $past(bus_wdata[6:0])) == '0));

    p_enable_read_top_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_addr == REG_ENAB) |-> bus_rdata[7]);

    p_mask_all_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_enab && bus_wdata == 8'h7F) |=> irq_n);

    p_clear_all_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_flag && bus_wdata == 8'hFF && set_vec == '0) |=> (flags == '0));

    p_guarded_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (CLR_NEEDS_TOP && wr_flag && !bus_wdata[7]) |=>
        ((flags & $past(flags)) == $past(flags)));

    p_read_top_vs_irq_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_addr == REG_FLAG) |-> (bus_rdata[7] == !irq_n));

    p_event_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

    p_flags_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!wr_flag && set_vec == '0) |=> $stable(flags));

endmodule

bind irq_unit irqu_checker #(.CLR_NEEDS_TOP(CLR_NEEDS_TOP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_n     (irq_n),
    .flags     (flag_q),
    .enables   (en_q),
    .set_vec   (set_vec)
);

// File: tb/irq_unit_tb.sv
`timescale 1ns/1ps
module irq_unit_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic       en = 0, we = 0;
    logic [1:0] addr = 0;
    logic [7:0] wd = 0;
    logic       a1 = 0, a2 = 0, b1 = 0, b2 = 0;
    logic       t1 = 0, t2 = 0, sr = 0;
    logic [7:0] rd_a, rd_b;
    logic       irq_a, irq_b;

    irq_unit #(.CLR_NEEDS_TOP(1'b0)) u_dut (
        .clk(clk), .rst(rst), .bus_en(en), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wd), .bus_rdata(rd_a), .line_a1(a1), .line_a2(a2),
        .line_b1(b1), .line_b2(b2), .evt_t1(t1), .evt_t2(t2), .evt_sr(sr),
        .irq_n(irq_a));

    irq_unit #(.CLR_NEEDS_TOP(1'b1)) u_dut_alt (
        .clk(clk), .rst(rst), .bus_en(en), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wd), .bus_rdata(rd_b), .line_a1(a1), .line_a2(a2),
        .line_b1(b1), .line_b2(b2), .evt_t1(t1), .evt_t2(t2), .evt_sr(sr),
        .irq_n(irq_b));

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model
    logic [7:0] m_ctrl = 0;
    logic [6:0] m_f [2];
    logic [6:0] m_e [2];
    logic [3:0] m_prev = 0;   // {b2,b1,a2,a1}

    function automatic logic edge_ok(input logic rise, input logic p, input logic c);
        return rise ? (!p && c) : (p && !c);
    endfunction

    function automatic logic [6:0] events(input logic [7:0] c, input logic [3:0] p,
                                           input logic [3:0] cur);
        logic [6:0] s;
        s    = '0;
        s[1] = edge_ok(c[0], p[0], cur[0]);
        s[0] = !c[3] && edge_ok(c[2], p[1], cur[1]);
        s[4] = edge_ok(c[4], p[2], cur[2]);
        s[3] = !c[7] && edge_ok(c[6], p[3], cur[3]);
        s[2] = sr;
        s[5] = t2;
        s[6] = t1;
        return s;
    endfunction

    function automatic logic [7:0] exp_rd(input int v);
        if (!en) return 8'h00;
        case (addr)
            2'd0:    return m_ctrl;
            2'd1:    return {|(m_f[v] & m_e[v]), m_f[v]};
            2'd2:    return {1'b1, m_e[v]};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic [3:0] cur;
        logic [6:0] s, clr;
        cur = {b2, b1, a2, a1};
        s = events(m_ctrl, m_prev, cur);
        for (int v = 0; v < 2; v++) begin
            clr = '0;
            if (en && we && addr == 2'd1 && (v == 0 || wd[7])) clr = wd[6:0];
            m_f[v] = (m_f[v] & ~clr) | s;
            if (en && we && addr == 2'd2)
                m_e[v] = wd[7] ? (m_e[v] | wd[6:0]) : (m_e[v] & ~wd[6:0]);
        end
        if (en && we && addr == 2'd0) m_ctrl = wd;
        m_prev = cur;
    endtask

    // drives are set right after a falling edge; compare, then advance model
    task automatic cycle(input string tag);
        #1;
        chk(tag, "irq_n plain", {7'd0, irq_a}, {7'd0, !(|(m_f[0] & m_e[0]))});
        chk(tag, "irq_n guarded", {7'd0, irq_b}, {7'd0, !(|(m_f[1] & m_e[1]))});
        chk(tag, "rdata plain", rd_a, exp_rd(0));
        chk(tag, "rdata guarded", rd_b, exp_rd(1));
        model_step();
        @(negedge clk);
        en = 0; we = 0; t1 = 0; t2 = 0; sr = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        en = 1; we = 1; addr = a; wd = d;
    endtask

    task automatic rd(input logic [1:0] a);
        en = 1; we = 0; addr = a;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL R11 watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int r;
        m_f[0] = 0; m_f[1] = 0; m_e[0] = 0; m_e[1] = 0;
        void'($urandom(32'd4217));
        repeat (5) @(negedge clk);
        rst = 0;

        // R1 reset state
        rd(2'd1); cycle("R1");
        rd(2'd2); cycle("R1");
        rd(2'd0); cycle("R1");

        // R2 enable set/clear semantics
        wr(2'd2, 8'hC2); cycle("R2");
        rd(2'd2); cycle("R2");
        wr(2'd2, 8'h02); cycle("R2");
        rd(2'd2); cycle("R2");

        // R9 internal event pulses, R6 latching while disabled
        t2 = 1; sr = 1; rd(2'd1); cycle("R9");
        rd(2'd1); cycle("R9");
        t1 = 1; cycle("R9");
        rd(2'd1); cycle("R6");
        wr(2'd2, 8'hC0); cycle("R6");
        rd(2'd1); cycle("R6");

        // R3 disable all
        wr(2'd2, 8'h7F); cycle("R3");
        rd(2'd1); cycle("R3");
        wr(2'd2, 8'hFF); cycle("R6");

        // R4 / R5 clear rules
        wr(2'd1, 8'h40); cycle("R4 R5");
        rd(2'd1); cycle("R4 R5");
        wr(2'd1, 8'hFF); cycle("R5");
        rd(2'd1); cycle("R4");

        // R7 polarity of A1 / B1
        a1 = 1; rd(2'd1); cycle("R7");
        a1 = 0; rd(2'd1); cycle("R7");
        rd(2'd1); cycle("R7");
        wr(2'd0, 8'h11); cycle("R7");
        b1 = 1; rd(2'd1); cycle("R7");
        b1 = 0; a1 = 1; rd(2'd1); cycle("R7");
        rd(2'd1); cycle("R7");

        // R8 A2 / B2 modes
        wr(2'd1, 8'hFF); cycle("R8");
        wr(2'd0, 8'h22); cycle("R8");
        a2 = 1; b2 = 1; rd(2'd1); cycle("R8");
        a2 = 0; rd(2'd1); cycle("R8");
        b2 = 0; rd(2'd1); cycle("R8");
        wr(2'd0, 8'h66); cycle("R8");
        a2 = 1; b2 = 1; rd(2'd1); cycle("R8");
        wr(2'd1, 8'hFF); cycle("R8");
        wr(2'd0, 8'h88); cycle("R8");
        a2 = 0; b2 = 0; rd(2'd1); cycle("R8");
        a2 = 1; b2 = 1; rd(2'd1); cycle("R8");

        // R10 event and clear in the same cycle
        wr(2'd0, 8'h00); cycle("R10");
        wr(2'd1, 8'hFF); t1 = 1; a1 = 0; cycle("R10");
        rd(2'd1); cycle("R10");

        // R11 random mix
        for (int i = 0; i < 4000; i++) begin
            en = $urandom % 2;
            we = $urandom % 2;
            addr = $urandom % 4;
            r = $urandom % 8;
            wd = (r == 0) ? 8'h7F : (r == 1) ? 8'hFF : 8'($urandom);
            if ($urandom % 4 == 0) a1 = ~a1;
            if ($urandom % 4 == 0) a2 = ~a2;
            if ($urandom % 4 == 0) b1 = ~b1;
            if ($urandom % 4 == 0) b2 = ~b2;
            t1 = ($urandom % 8 == 0);
            t2 = ($urandom % 8 == 0);
            sr = ($urandom % 8 == 0);
            cycle("R11");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule